// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block holds the byte-addressed register file that software uses to control two bus-master DMA channels. The window spans 16 bytes, with an 8-byte slot per channel. Bit 3 of the address picks the channel and bit 2 picks the half of the slot. The low half contains four single-byte registers: a command byte, a view of one mode register that both channels share, a status byte and a per-channel timing byte. The high half holds a 32-bit descriptor-table base address.

The command register drives the start and direction bits to a DMA engine outside this block. The engine reports back through per-channel pulses for active, interrupt and error, and these set bits in the status byte. The shared mode register holds one interrupt-block bit per channel. It also reflects the per-channel interrupt-pending inputs. The block combines both into a single interrupt output.

Access size is coded as `io_size`: 0 for one byte, 1 for two bytes, 2 or 3 for four bytes. Byte k of `io_wdata` or `io_rdata` maps to window offset `io_addr + k`. Read data is combinational and is valid while `io_rd` is high. It reads as zero when `io_rd` is low. Writes take effect at the rising clock edge where `io_wr` is high.

Top module: `bm_dma_regwin`

## Requirements
- R1: After reset, every stored register is zero. The command outputs, the block outputs and the interrupt output are low while `irq_pend` is low.
- R2: In each slot, low-half offset 0 is the command byte, 1 is the shared mode byte, 2 is status and 3 is timing. Slot 0 is at window offset 0 and slot 1 at offset 8. A byte read returns the register in bits 7:0 with all upper bits zero.
- R3: A low-half access with `io_size` other than 0 is rejected. A read returns ones across the access width (0xFFFF for two bytes, 0xFFFFFFFF for four). A write changes nothing.
- R4: The command byte keeps bit 0 (start, driven on `cmd_start`) and bit 3 (direction, driven on `cmd_dir`). Its other bits read as 0.
- R5: A status write loads bits 6 and 5 from the data and leaves bit 0 unchanged. It clears bit 2 or bit 1 only where the data bit is 1. Status bits 7, 4 and 3 read as 0.
- R6: A command write with bit 0 at 0 clears status bit 0. This also happens when the engine reports active in the same cycle.
- R7: An engine pulse sets status bit 0 (`eng_active`), bit 2 (`eng_irq`) or bit 1 (`eng_err`) on the next edge. An engine set wins over a write-1-to-clear in the same cycle.
- R8: A byte write at offset 1 of either slot changes only mode bits 5 (channel 1 block) and 4 (channel 0 block). Mode bits 3 and 2 show `irq_pend[1]` and `irq_pend[0]`. Other mode bits read as 0. Both slots read the same mode byte.
- R9: `irq_out` is high when, for some channel, the pending input is high and that channel's block bit is clear. It reacts combinationally to `irq_pend` and to the registered block bits.
- R10: Each channel has its own timing byte. Writing one channel's timing byte leaves the other channel's unchanged.
- R11: The descriptor register accepts accesses of any size with byte enables. Bytes that would fall past offset 7 are dropped. Bits 1:0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 4 | Byte offset into the window |
| io_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data, byte k to offset io_addr+k |
| io_rdata | output | 32 | Read data, valid while io_rd is high |
| eng_active | input | 2 | Per-channel engine active pulse |
| eng_irq | input | 2 | Per-channel engine interrupt pulse |
| eng_err | input | 2 | Per-channel engine error pulse |
| irq_pend | input | 2 | Per-channel interrupt-pending level |
| cmd_start | output | 2 | Per-channel start bit |
| cmd_dir | output | 2 | Per-channel direction bit |
| blk_mask | output | 2 | Per-channel interrupt-block bits |
| irq_out | output | 1 | Combined interrupt level |

## Verification
The bench builds the block with its default parameters: two channels over a 32-bit data path. This exposes the mode-register alias from both slots, keeps the two timing bytes separate, and lets descriptor accesses of one, two and four bytes reach every lane, including those clipped at the slot end. The 32-bit path also gives room for both rejected-read patterns, and the status cases drive engine pulses in the same cycle as software writes to exercise the priority rules.

// File: rtl/bmw_pkg.sv
`timescale 1ns/1ps
package bmw_pkg;
    localparam int IO_DW   = 32;
    localparam int LANES   = IO_DW / 8;
    localparam int DESC_W  = IO_DW;
    localparam int SLOT_AW = 3;

    // Status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_INT  = 2;

    typedef struct packed {
        logic              start;
        logic              dir;
        logic [7:0]        stat;
        logic [7:0]        tim;
        logic [DESC_W-1:0] desc;
    } chan_state_t;
endpackage

// File: rtl/bmw_decode.sv
`timescale 1ns/1ps
module bmw_decode #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [1:0]               size,
    output logic [CH_W-1:0]          sel_ch,
    output logic                     ch_ok,
    output logic                     hi,
    output logic                     wide,
    output logic [1:0]               off,
    output logic [bmw_pkg::LANES-1:0] lane_be,
    output logic [bmw_pkg::IO_DW-1:0] width_mask
);
    import bmw_pkg::*;

    int nbytes;

    always_comb begin
        sel_ch = addr[ADDR_W-1 -: CH_W];
        ch_ok  = (int'(sel_ch) < NUM_CH);
        hi     = addr[2];
        off    = addr[1:0];
        wide   = (size != 2'd0);
        case (size)
            2'd0:    nbytes = 1;
            2'd1:    nbytes = 2;
            default: nbytes = 4;
        endcase
        for (int k = 0; k < LANES; k++) begin
            lane_be[k] = (k >= int'(off)) && ((k - int'(off)) < nbytes);
        end
        for (int b = 0; b < LANES; b++) begin
            width_mask[8*b +: 8] = (b < nbytes) ? 8'hFF : 8'h00;
        end
    end
endmodule

// File: rtl/bmw_chan.sv
`timescale 1ns/1ps
module bmw_chan (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_we,
    input  logic                       stat_we,
    input  logic                       tim_we,
    input  logic [bmw_pkg::LANES-1:0]  desc_be,
    input  logic [7:0]                 wbyte,
    input  logic [bmw_pkg::DESC_W-1:0] desc_wdata,
    input  logic                       eng_active,
    input  logic                       eng_irq,
    input  logic                       eng_err,
    output bmw_pkg::chan_state_t       st_q
);
    import bmw_pkg::*;

    chan_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (cmd_we) begin
            st_d.start = wbyte[0];
            st_d.dir   = wbyte[3];
        end
        // keep only the implemented status bits
        st_d.stat = st_q.stat & 8'h67;
        if (stat_we) begin
            st_d.stat[6:5]           = wbyte[6:5];
            st_d.stat[ST_INT:ST_ERR] = st_q.stat[ST_INT:ST_ERR] & ~wbyte[ST_INT:ST_ERR];
        end
        if (cmd_we && !wbyte[0]) begin
            st_d.stat[ST_BUSY] = 1'b0;
        end else if (eng_active) begin
            st_d.stat[ST_BUSY] = 1'b1;
        end
        if (eng_irq) st_d.stat[ST_INT] = 1'b1;
        if (eng_err) st_d.stat[ST_ERR] = 1'b1;
        if (tim_we)  st_d.tim = wbyte;
        for (int b = 0; b < LANES; b++) begin
            if (desc_be[b]) st_d.desc[8*b +: 8] = desc_wdata[8*b +: 8];
        end
        st_d.desc[1:0] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_stop_clears_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !wbyte[0]) |=> !st_q.stat[ST_BUSY]);
    assert_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> st_q.stat[ST_ERR]);
    assert_irq_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_irq && stat_we && wbyte[ST_INT]) |=> st_q.stat[ST_INT]);
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && wbyte[ST_INT] && !eng_irq) |=> !st_q.stat[ST_INT]);
    assert_desc_full_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_be == '1) |=> (st_q.desc == {$past(desc_wdata[DESC_W-1:2]), 2'b00}));
endmodule

// File: rtl/bmw_mode.sv
`timescale 1ns/1ps
module bmw_mode #(
    parameter int NUM_CH  = 2,
    parameter int BLK_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        wbyte,
    output logic [NUM_CH-1:0] blk_q
);
    logic [NUM_CH-1:0] blk_d;

    always_comb begin
        blk_d = blk_q;
        if (we) blk_d = wbyte[BLK_LSB +: NUM_CH];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= blk_d;
    end

    assert_mode_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (blk_q == $past(wbyte[BLK_LSB +: NUM_CH])));
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(blk_q));
endmodule

// File: rtl/bm_dma_regwin.sv
`timescale 1ns/1ps
module bm_dma_regwin #(
    parameter int NUM_CH   = 2,
    parameter int PEND_LSB = 2,
    parameter int BLK_LSB  = 4,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W  = CH_W + bmw_pkg::SLOT_AW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         io_addr,
    input  logic [1:0]                io_size,
    input  logic                      io_rd,
    input  logic                      io_wr,
    input  logic [bmw_pkg::IO_DW-1:0] io_wdata,
    output logic [bmw_pkg::IO_DW-1:0] io_rdata,
    input  logic [NUM_CH-1:0]         eng_active,
    input  logic [NUM_CH-1:0]         eng_irq,
    input  logic [NUM_CH-1:0]         eng_err,
    input  logic [NUM_CH-1:0]         irq_pend,
    output logic [NUM_CH-1:0]         cmd_start,
    output logic [NUM_CH-1:0]         cmd_dir,
    output logic [NUM_CH-1:0]         blk_mask,
    output logic                      irq_out
);
    import bmw_pkg::*;

    logic [CH_W-1:0]  sel_ch;
    logic             ch_ok, hi, wide;
    logic [1:0]       off;
    logic [LANES-1:0] lane_be;
    logic [IO_DW-1:0] width_mask;
    logic             byte_ok;
    logic             mode_we;
    logic [7:0]       mode_byte;
    logic [DESC_W-1:0] desc_wdata;

    chan_state_t            ch_q   [NUM_CH];
    logic [NUM_CH-1:0][7:0] tim_all;
    logic [NUM_CH-1:0]      cmd_we_v, stat_we_v, tim_we_v;
    logic [LANES-1:0]       desc_be_v [NUM_CH];

    bmw_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .addr       (io_addr),
        .size       (io_size),
        .sel_ch     (sel_ch),
        .ch_ok      (ch_ok),
        .hi         (hi),
        .wide       (wide),
        .off        (off),
        .lane_be    (lane_be),
        .width_mask (width_mask)
    );

    assign byte_ok    = io_wr && ch_ok && !hi && !wide;
    assign mode_we    = byte_ok && (off == 2'd1);
    assign desc_wdata = io_wdata << (8 * off);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            logic hit;
            assign hit          = (int'(sel_ch) == g);
            assign cmd_we_v[g]  = byte_ok && hit && (off == 2'd0);
            assign stat_we_v[g] = byte_ok && hit && (off == 2'd2);
            assign tim_we_v[g]  = byte_ok && hit && (off == 2'd3);
            assign desc_be_v[g] = (io_wr && ch_ok && hi && hit) ? lane_be : '0;

            bmw_chan u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .cmd_we     (cmd_we_v[g]),
                .stat_we    (stat_we_v[g]),
                .tim_we     (tim_we_v[g]),
                .desc_be    (desc_be_v[g]),
                .wbyte      (io_wdata[7:0]),
                .desc_wdata (desc_wdata),
                .eng_active (eng_active[g]),
                .eng_irq    (eng_irq[g]),
                .eng_err    (eng_err[g]),
                .st_q       (ch_q[g])
            );

            assign cmd_start[g] = ch_q[g].start;
            assign cmd_dir[g]   = ch_q[g].dir;
            assign tim_all[g]   = ch_q[g].tim;
        end
    endgenerate

    bmw_mode #(.NUM_CH(NUM_CH), .BLK_LSB(BLK_LSB)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_we),
        .wbyte (io_wdata[7:0]),
        .blk_q (blk_mask)
    );

    always_comb begin
        mode_byte = '0;
        mode_byte[PEND_LSB +: NUM_CH] = irq_pend;
        mode_byte[BLK_LSB  +: NUM_CH] = blk_mask;
    end

    assign irq_out = |(irq_pend & ~blk_mask);

    always_comb begin
        io_rdata = '0;
        if (io_rd && ch_ok) begin
            if (hi) begin
                io_rdata = (ch_q[sel_ch].desc >> (8 * off)) & width_mask;
            end else if (wide) begin
                io_rdata = width_mask;
            end else begin
                case (off)
                    2'd0: io_rdata[7:0] = {4'b0, ch_q[sel_ch].dir, 2'b0, ch_q[sel_ch].start};
                    2'd1: io_rdata[7:0] = mode_byte;
                    2'd2: io_rdata[7:0] = ch_q[sel_ch].stat;
                    default: io_rdata[7:0] = ch_q[sel_ch].tim;
                endcase
            end
        end
    end

    assert_wide_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !hi && wide) |=> ($stable(blk_mask) && $stable(tim_all) && $stable(cmd_start) && $stable(cmd_dir)));
    assert_one_cmd_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_we_v | stat_we_v | tim_we_v));
endmodule

// File: tb/bm_dma_regwin_bench.sv
`timescale 1ns/1ps
module bm_dma_regwin_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [1:0]  eng_active = '0, eng_irq = '0, eng_err = '0, irq_pend = '0;
    logic [1:0]  cmd_start, cmd_dir, blk_mask;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bm_dma_regwin u_bm_dma_regwin (
        .clk(clk), .rst_n(rst_n),
        .io_addr(io_addr), .io_size(io_size), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .eng_active(eng_active), .eng_irq(eng_irq), .eng_err(eng_err),
        .irq_pend(irq_pend),
        .cmd_start(cmd_start), .cmd_dir(cmd_dir), .blk_mask(blk_mask),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        io_addr = a; io_size = s; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
        io_addr = a; io_size = s; io_rd = 1'b1;
        #1;
        d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), 2'd0, v);
            chk($sformatf("R1 reset byte %0d", a), v, 32'h0);
        end
        chk("R1 reset outputs", {25'b0, irq_out, blk_mask, cmd_dir, cmd_start}, 32'h0);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        wr(4'h0, 2'd0, 32'hFF);
        rd(4'h0, 2'd0, v);
        chk("R4 cmd readback", v, 32'h09);
        chk("R4 start/dir outputs", {28'b0, cmd_dir, cmd_start}, {28'b0, 2'b01, 2'b01});
        rd(4'h8, 2'd0, v);
        chk("R2 ch1 cmd untouched", v, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        eng_err = 2'b01; eng_irq = 2'b01;
        @(negedge clk);
        eng_err = '0; eng_irq = '0;
        rd(4'h2, 2'd0, v);
        chk("R7 engine irq+err", v, 32'h06);
        wr(4'h2, 2'd0, 32'hFF);
        rd(4'h2, 2'd0, v);
        chk("R5 write ff", v, 32'h60);
        eng_active = 2'b01;
        @(negedge clk);
        eng_active = '0;
        rd(4'h2, 2'd0, v);
        chk("R7 engine active", v, 32'h61);
        wr(4'h2, 2'd0, 32'h04);
        rd(4'h2, 2'd0, v);
        chk("R5 busy kept, 6:5 loaded", v, 32'h01);
        eng_irq = 2'b01;
        wr(4'h2, 2'd0, 32'h04);
        eng_irq = '0;
        rd(4'h2, 2'd0, v);
        chk("R7 engine set beats clear", v, 32'h05);
        rd(4'hA, 2'd0, v);
        chk("R2 ch1 status untouched", v, 32'h0);
        eng_active = 2'b01;
        wr(4'h0, 2'd0, 32'h00);
        eng_active = '0;
        rd(4'h2, 2'd0, v);
        chk("R6 stop clears busy", v, 32'h04);
        chk("R4 start cleared", {30'b0, cmd_start}, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        irq_pend = 2'b01;
        #1;
        chk("R9 pending unblocked", {31'b0, irq_out}, 32'h1);
        rd(4'h1, 2'd0, v);
        chk("R8 pending reflected", v, 32'h04);
        @(negedge clk);
        wr(4'h1, 2'd0, 32'hFF);
        rd(4'h9, 2'd0, v);
        chk("R8 alias from slot 1", v, 32'h34);
        chk("R9 blocked", {31'b0, irq_out}, 32'h0);
        irq_pend = 2'b11;
        wr(4'h9, 2'd0, 32'h10);
        chk("R8 blk outputs", {30'b0, blk_mask}, 32'h1);
        chk("R9 ch1 unblocked", {31'b0, irq_out}, 32'h1);
        rd(4'h1, 2'd0, v);
        chk("R8 alias from slot 0", v, 32'h1C);
        irq_pend = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        wr(4'h3, 2'd0, 32'hA5);
        wr(4'hB, 2'd0, 32'h3C);
        rd(4'h3, 2'd0, v);
        chk("R10 ch0 timing", v, 32'hA5);
        rd(4'hB, 2'd0, v);
        chk("R10 ch1 timing", v, 32'h3C);
    endtask

    task automatic t_desc();
        logic [31:0] v;
        wr(4'h4, 2'd2, 32'h12345677);
        rd(4'h4, 2'd2, v);
        chk("R11 full write low bits", v, 32'h12345674);
        wr(4'hC, 2'd0, 32'hFF);
        rd(4'hC, 2'd2, v);
        chk("R11 ch1 byte write", v, 32'h000000FC);
        rd(4'hE, 2'd1, v);
        chk("R11 ch1 upper half", v, 32'h0);
        @(negedge clk);
        wr(4'h6, 2'd1, 32'hBEEF);
        rd(4'h4, 2'd2, v);
        chk("R11 half write", v, 32'hBEEF5674);
        rd(4'h5, 2'd0, v);
        chk("R11 byte read", v, 32'h56);
        rd(4'h7, 2'd2, v);
        chk("R11 clipped read", v, 32'hBE);
        @(negedge clk);
        wr(4'h7, 2'd2, 32'h11223300);
        rd(4'h4, 2'd2, v);
        chk("R11 clipped write", v, 32'h00EF5674);
    endtask

    task automatic t_wide();
        logic [31:0] v;
        rd(4'h0, 2'd1, v);
        chk("R3 wide read 2", v, 32'h0000FFFF);
        rd(4'hA, 2'd2, v);
        chk("R3 wide read 4", v, 32'hFFFFFFFF);
        @(negedge clk);
        wr(4'h0, 2'd0, 32'h01);
        wr(4'h0, 2'd1, 32'h0000);
        chk("R3 wide cmd write ignored", {30'b0, cmd_start}, 32'h1);
        wr(4'h3, 2'd1, 32'h0000);
        rd(4'h3, 2'd0, v);
        chk("R3 wide timing write ignored", v, 32'hA5);
        wr(4'h1, 2'd2, 32'h0);
        chk("R3 wide mode write ignored", {30'b0, blk_mask}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd();
        t_status();
        t_mode();
        t_timing();
        t_desc();
        t_wide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule